// File: doc/BRIEF.md
# Shared Converter Channel Allocator for a Detector Column

This block sits between one column of photon-detector pixels and a small pool of time-to-digital converter channels. Each clock cycle it looks at the pixels that fired and hands every free converter channel to one of them. Any channel can serve any pixel. A channel returns to the pool as soon as its conversion finishes, so the pool is reused continuously and few detections are lost.

Each grant is registered and carries the index of the pixel it serves. When the programmed conversion time has elapsed, the channel emits a single-cycle readout record holding the pixel index and the converter's timestamp code. Only pixels that actually fired produce records, so readout is event driven. A pixel that fires and is not served is counted in a saturating lost-event counter. Priority among simultaneous requesters rotates so that no pixel is permanently starved.

The default configuration is 32 pixels, 4 converter channels, 12-bit timestamps with a 50 ps step, and a 4-cycle conversion time.

Top module: `tdc_share_alloc`

## Requirements
- R1: While reset is applied and after it is released, with no pixel activity, all of `gnt_vld`, `ch_busy` and `evt_vld` are 0 and `lost_cnt` is 0.
- R2: A pixel strobe sampled at a clock edge and served by channel c sets `gnt_vld[c]` for the one cycle after that edge. `ch_busy[c]` is then high for exactly CONV_CYCLES cycles.
- R3: At each edge, free channels are filled in ascending channel order. Requesters are taken in priority order, starting at the current priority pointer and wrapping through increasing pixel index. `gnt_pix[c*5 +: 5]` holds the pixel index served by channel c.
- R4: The priority pointer is 0 after reset. It advances by one, with 31 wrapping to 0, after every edge at which at least one pixel strobe is high. It holds otherwise.
- R5: No pixel is ever held by two busy channels. A strobe from a pixel whose channel is still busy is not served and counts as lost.
- R6: At each edge, `lost_cnt` increases by the number of asserted strobes that were not granted. It saturates at 65535.
- R7: At the edge where a channel's busy interval ends, `evt_vld[c]` pulses for one cycle. `evt_pix[c*5 +: 5]` gives the served pixel, and `evt_stamp[c*12 +: 12]` gives the value of `ch_stamp[c*12 +: 12]` sampled at that edge, unchanged, in 50 ps units.
- R8: A channel can be granted again at the first edge after the one that cleared its busy flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronized internally |
| pix_evt | input | 32 | Per-pixel detection strobe, one event per asserted cycle |
| ch_stamp | input | 48 | Per-channel converter timestamp code, 12 bits per channel, 50 ps LSB |
| ch_busy | output | 4 | Channel is converting |
| gnt_vld | output | 4 | Channel was granted at the last edge |
| gnt_pix | output | 20 | Pixel index held by each channel, 5 bits per channel |
| evt_vld | output | 4 | Readout record valid for the channel |
| evt_pix | output | 20 | Pixel index of each readout record |
| evt_stamp | output | 48 | Timestamp of each readout record |
| lost_cnt | output | 16 | Saturating count of unserved pixel events |

## Verification
Grants and the lost-count increment for a set of strobes become visible one edge after the strobes are sampled. A readout record appears CONV_CYCLES edges after its grant, and a regrant of the same channel can appear one edge after that. The bench sets its inputs at a falling edge and advances a reference model by exactly one rising edge. At the next falling edge it compares every output against that model, so each result is checked in the cycle it is due. Directed checks measure the grant-to-regrant spacing and the priority-pointer positions directly.

// File: rtl/tdc_alloc_pkg.sv
package tdc_alloc_pkg;
  localparam int unsigned NPIX_DEF   = 32;
  localparam int unsigned NCH_DEF    = 4;
  localparam int unsigned STAMP_W    = 12;  // 50 ps per LSB
  localparam int unsigned CONV_DEF   = 4;
  localparam int unsigned LOST_W_DEF = 16;
endpackage

// File: rtl/tdc_alloc_arbiter.sv
module tdc_alloc_arbiter #(
  parameter int unsigned NPIX = 32,
  parameter int unsigned NCH  = 4,
  localparam int unsigned IDXW = $clog2(NPIX),
  localparam int unsigned NGW  = $clog2(NCH + 1)
) (
  input  logic [NPIX-1:0]      req_i,
  input  logic [NCH-1:0]       free_i,
  input  logic [IDXW-1:0]      ptr_i,
  output logic [NCH-1:0]       grant_o,
  output logic [NCH*IDXW-1:0]  gpix_o,
  output logic [NGW-1:0]       ngrant_o
);
  logic [NPIX-1:0] rot;
  logic [NPIX-1:0] rem;
  logic [IDXW-1:0] sel;
  logic            found;

  always_comb begin
    rot      = NPIX'({req_i, req_i} >> ptr_i);
    rem      = rot;
    grant_o  = '0;
    gpix_o   = '0;
    ngrant_o = '0;
    sel      = '0;
    found    = 1'b0;
    for (int c = 0; c < NCH; c++) begin
      found = 1'b0;
      sel   = '0;
      if (free_i[c]) begin
        for (int k = 0; k < NPIX; k++) begin
          if (!found && rem[k]) begin
            found = 1'b1;
            sel   = IDXW'(k);
          end
        end
      end
      if (found) begin
        grant_o[c]                = 1'b1;
        gpix_o[c*IDXW +: IDXW]    = sel + ptr_i;
        rem[sel]                  = 1'b0;
        ngrant_o                  = ngrant_o + NGW'(1);
      end
    end
  end
endmodule

// File: rtl/tdc_alloc_channel.sv
module tdc_alloc_channel #(
  parameter int unsigned IDXW        = 5,
  parameter int unsigned TSW         = 12,
  parameter int unsigned CONV_CYCLES = 4,
  localparam int unsigned CNTW = $clog2(CONV_CYCLES + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            grant_i,
  input  logic [IDXW-1:0] gpix_i,
  input  logic [TSW-1:0]  stamp_i,
  output logic            busy_o,
  output logic [IDXW-1:0] pix_o,
  output logic            gnt_vld_o,
  output logic            evt_vld_o,
  output logic [IDXW-1:0] evt_pix_o,
  output logic [TSW-1:0]  evt_stamp_o
);
  logic [CNTW-1:0] cnt_q, cnt_d;
  logic [IDXW-1:0] pix_q;
  logic            gv_q, ev_q;
  logic [IDXW-1:0] epix_q;
  logic [TSW-1:0]  est_q;
  logic            done;

  assign done = (cnt_q == CNTW'(1));

  always_comb begin
    cnt_d = cnt_q;
    if (grant_i)
      cnt_d = CNTW'(CONV_CYCLES);
    else if (cnt_q != '0)
      cnt_d = cnt_q - CNTW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      gv_q  <= 1'b0;
      ev_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      gv_q  <= grant_i;
      ev_q  <= done;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      pix_q <= '0;
    else if (grant_i)
      pix_q <= gpix_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      epix_q <= '0;
      est_q  <= '0;
    end else if (done) begin
      epix_q <= pix_q;
      est_q  <= stamp_i;
    end
  end

  assign busy_o      = (cnt_q != '0);
  assign pix_o       = pix_q;
  assign gnt_vld_o   = gv_q;
  assign evt_vld_o   = ev_q;
  assign evt_pix_o   = epix_q;
  assign evt_stamp_o = est_q;
endmodule

// File: rtl/tdc_alloc_lost_ctr.sv
module tdc_alloc_lost_ctr #(
  parameter int unsigned W  = 16,
  parameter int unsigned DW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] add_i,
  output logic [W-1:0]  cnt_o
);
  logic [W-1:0] cnt_q, cnt_d;
  logic [W:0]   sum;
  logic         en;

  assign en  = (add_i != '0);
  assign sum = {1'b0, cnt_q} + (W+1)'(add_i);

  always_comb begin
    if (sum[W]) cnt_d = '1;
    else        cnt_d = sum[W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  cnt_q <= '0;
    else if (en) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/tdc_share_alloc.sv
module tdc_share_alloc
  import tdc_alloc_pkg::*;
#(
  parameter int unsigned NPIX        = NPIX_DEF,
  parameter int unsigned NCH         = NCH_DEF,
  parameter int unsigned TSW         = STAMP_W,
  parameter int unsigned CONV_CYCLES = CONV_DEF,
  parameter int unsigned LOST_W      = LOST_W_DEF,
  localparam int unsigned IDXW = $clog2(NPIX),
  localparam int unsigned PCW  = $clog2(NPIX + 1),
  localparam int unsigned NGW  = $clog2(NCH + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NPIX-1:0]      pix_evt,
  input  logic [NCH*TSW-1:0]   ch_stamp,
  output logic [NCH-1:0]       ch_busy,
  output logic [NCH-1:0]       gnt_vld,
  output logic [NCH*IDXW-1:0]  gnt_pix,
  output logic [NCH-1:0]       evt_vld,
  output logic [NCH*IDXW-1:0]  evt_pix,
  output logic [NCH*TSW-1:0]   evt_stamp,
  output logic [LOST_W-1:0]    lost_cnt
);
  logic            rs_q1, rs_q2, rst_int_n;
  logic [IDXW-1:0] ptr_q, ptr_d;
  logic            any_req;
  logic [NPIX-1:0] owned, req_eff;
  logic [NCH-1:0]  grant;
  logic [NCH*IDXW-1:0] gpix;
  logic [NGW-1:0]  ngrant;
  logic [PCW-1:0]  drops;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_q1 <= 1'b0;
      rs_q2 <= 1'b0;
    end else begin
      rs_q1 <= 1'b1;
      rs_q2 <= rs_q1;
    end
  end
  assign rst_int_n = rs_q2;

  assign any_req = |pix_evt;

  always_comb begin
    owned = '0;
    for (int c = 0; c < NCH; c++)
      if (ch_busy[c]) owned[gnt_pix[c*IDXW +: IDXW]] = 1'b1;
    req_eff = pix_evt & ~owned;
  end

  always_comb begin
    ptr_d = ptr_q;
    if (any_req) ptr_d = ptr_q + IDXW'(1);
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) ptr_q <= '0;
    else            ptr_q <= ptr_d;
  end

  tdc_alloc_arbiter #(.NPIX(NPIX), .NCH(NCH)) u_arb (
    .req_i    (req_eff),
    .free_i   (~ch_busy),
    .ptr_i    (ptr_q),
    .grant_o  (grant),
    .gpix_o   (gpix),
    .ngrant_o (ngrant)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    tdc_alloc_channel #(.IDXW(IDXW), .TSW(TSW), .CONV_CYCLES(CONV_CYCLES)) u_ch (
      .clk         (clk),
      .rst_n       (rst_int_n),
      .grant_i     (grant[c]),
      .gpix_i      (gpix[c*IDXW +: IDXW]),
      .stamp_i     (ch_stamp[c*TSW +: TSW]),
      .busy_o      (ch_busy[c]),
      .pix_o       (gnt_pix[c*IDXW +: IDXW]),
      .gnt_vld_o   (gnt_vld[c]),
      .evt_vld_o   (evt_vld[c]),
      .evt_pix_o   (evt_pix[c*IDXW +: IDXW]),
      .evt_stamp_o (evt_stamp[c*TSW +: TSW])
    );
  end

  assign drops = PCW'($countones(pix_evt)) - PCW'(ngrant);

  tdc_alloc_lost_ctr #(.W(LOST_W), .DW(PCW)) u_lost (
    .clk   (clk),
    .rst_n (rst_int_n),
    .add_i (drops),
    .cnt_o (lost_cnt)
  );
endmodule

// File: rtl/tdc_alloc_chk.sv
module tdc_alloc_chk #(
  parameter int unsigned NCH    = 4,
  parameter int unsigned IDXW   = 5,
  parameter int unsigned LOST_W = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic [NCH-1:0]      ch_busy,
  input logic [NCH-1:0]      gnt_vld,
  input logic [NCH*IDXW-1:0] gnt_pix,
  input logic [NCH-1:0]      evt_vld,
  input logic [LOST_W-1:0]   lost_cnt
);
  for (genvar c = 0; c < NCH; c++) begin : g_c
    // R2
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ch_busy[c]) |-> gnt_vld[c]);
    // R8
    grant_when_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
      gnt_vld[c] |-> $past(!ch_busy[c]));
    // R7
    evt_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      evt_vld[c] |-> (!ch_busy[c] && $past(ch_busy[c])));
    for (genvar d = c + 1; d < NCH; d++) begin : g_d
      // R5
      unique_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_busy[c] && ch_busy[d]) |->
          (gnt_pix[c*IDXW +: IDXW] != gnt_pix[d*IDXW +: IDXW]));
    end
  end
  // R6
  lost_monotone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lost_cnt >= $past(lost_cnt));
endmodule

bind tdc_share_alloc tdc_alloc_chk #(.NCH(NCH), .IDXW(IDXW), .LOST_W(LOST_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ch_busy  (ch_busy),
  .gnt_vld  (gnt_vld),
  .gnt_pix  (gnt_pix),
  .evt_vld  (evt_vld),
  .lost_cnt (lost_cnt)
);

// File: tb/tdc_share_alloc_bench.sv
`timescale 1ns/1ps
module tdc_share_alloc_bench;
  localparam int NPIX = 32;
  localparam int NCH  = 4;
  localparam int TSW  = 12;
  localparam int C    = 4;
  localparam int IDXW = 5;

  logic                clk = 1'b0;
  logic                rst_n;
  logic [NPIX-1:0]     pix_evt;
  logic [NCH*TSW-1:0]  ch_stamp;
  logic [NCH-1:0]      ch_busy, gnt_vld, evt_vld;
  logic [NCH*IDXW-1:0] gnt_pix, evt_pix;
  logic [NCH*TSW-1:0]  evt_stamp;
  logic [15:0]         lost_cnt;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  int m_cnt[NCH], m_pix[NCH], m_gv[NCH], m_ev[NCH], m_epix[NCH], m_est[NCH];
  int m_ptr, m_lost;

  always #4 clk = ~clk;

  tdc_share_alloc #(.CONV_CYCLES(C)) u_tdc_share_alloc (
    .clk(clk), .rst_n(rst_n), .pix_evt(pix_evt), .ch_stamp(ch_stamp),
    .ch_busy(ch_busy), .gnt_vld(gnt_vld), .gnt_pix(gnt_pix),
    .evt_vld(evt_vld), .evt_pix(evt_pix), .evt_stamp(evt_stamp),
    .lost_cnt(lost_cnt)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    for (int c = 0; c < NCH; c++) begin
      chk(int'(gnt_vld[c]) == m_gv[c], "R3 grant valid", int'(gnt_vld[c]), m_gv[c]);
      if (m_gv[c] != 0)
        chk(int'(gnt_pix[c*IDXW +: IDXW]) == m_pix[c], "R3 grant pixel",
            int'(gnt_pix[c*IDXW +: IDXW]), m_pix[c]);
      chk(int'(ch_busy[c]) == int'(m_cnt[c] != 0), "R2 busy", int'(ch_busy[c]), int'(m_cnt[c] != 0));
      chk(int'(evt_vld[c]) == m_ev[c], "R7 event valid", int'(evt_vld[c]), m_ev[c]);
      if (m_ev[c] != 0) begin
        chk(int'(evt_pix[c*IDXW +: IDXW]) == m_epix[c], "R7 event pixel",
            int'(evt_pix[c*IDXW +: IDXW]), m_epix[c]);
        chk(int'(evt_stamp[c*TSW +: TSW]) == m_est[c], "R7 event stamp",
            int'(evt_stamp[c*TSW +: TSW]), m_est[c]);
      end
    end
    chk(int'(lost_cnt) == m_lost, "R6 lost count", int'(lost_cnt), m_lost);
  endtask

  // one rising edge: drive inputs, advance reference, compare at next falling edge
  task automatic cyc(input logic [NPIX-1:0] req);
    logic [NPIX-1:0] owned, rem;
    logic [NCH*TSW-1:0] st;
    int ng, drops, p;
    bit hit;
    for (int c = 0; c < NCH; c++) st[c*TSW +: TSW] = TSW'($urandom);
    pix_evt  = req;
    ch_stamp = st;
    owned = '0;
    for (int c = 0; c < NCH; c++) if (m_cnt[c] != 0) owned[m_pix[c]] = 1'b1;
    rem = req & ~owned;
    ng = 0;
    for (int c = 0; c < NCH; c++) begin
      m_gv[c] = 0;
      m_ev[c] = int'(m_cnt[c] == 1);
      if (m_ev[c] != 0) begin
        m_epix[c] = m_pix[c];
        m_est[c]  = int'(st[c*TSW +: TSW]);
      end
      if (m_cnt[c] == 0) begin
        hit = 0;
        for (int k = 0; k < NPIX; k++) begin
          p = (m_ptr + k) % NPIX;
          if (!hit && rem[p]) begin
            hit = 1; rem[p] = 1'b0; m_pix[c] = p;
          end
        end
        if (hit) begin m_gv[c] = 1; m_cnt[c] = C; ng++; end
      end else begin
        m_cnt[c] = m_cnt[c] - 1;
      end
    end
    drops = $countones(req) - ng;
    m_lost = (m_lost + drops > 65535) ? 65535 : m_lost + drops;
    if (req != '0) m_ptr = (m_ptr + 1) % NPIX;
    @(negedge clk);
    compare_all();
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [NPIX-1:0] r;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; pix_evt = '0; ch_stamp = '0;
    for (int c = 0; c < NCH; c++) begin
      m_cnt[c] = 0; m_pix[c] = 0; m_gv[c] = 0; m_ev[c] = 0; m_epix[c] = 0; m_est[c] = 0;
    end
    m_ptr = 0; m_lost = 0;
    repeat (3) @(negedge clk);
    // R1 during reset
    chk(gnt_vld == '0 && ch_busy == '0 && evt_vld == '0 && lost_cnt == '0,
        "R1 in reset", int'(lost_cnt), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 after release
    chk(gnt_vld == '0 && ch_busy == '0 && evt_vld == '0, "R1 outputs idle",
        int'({gnt_vld, ch_busy, evt_vld}), 0);
    chk(lost_cnt == '0, "R1 lost zero", int'(lost_cnt), 0);

    // R4: pointer starts at 0 -> channels take pixels 0..3
    cyc('1);
    for (int c = 0; c < NCH; c++)
      chk(int'(gnt_pix[c*IDXW +: IDXW]) == c, "R4 first burst", int'(gnt_pix[c*IDXW +: IDXW]), c);
    chk(int'(lost_cnt) == 28, "R6 burst loss", int'(lost_cnt), 28);
    repeat (C + 1) cyc('0);
    // R4: pointer advanced by one -> pixels 1..4
    cyc('1);
    for (int c = 0; c < NCH; c++)
      chk(int'(gnt_pix[c*IDXW +: IDXW]) == c + 1, "R4 second burst",
          int'(gnt_pix[c*IDXW +: IDXW]), c + 1);
    repeat (C + 1) cyc('0);

    // R5: a held pixel fires again and is lost, not granted twice
    cyc(32'h1 << 7);
    cyc(32'h1 << 7);
    chk(gnt_vld == '0, "R5 no second channel", int'(gnt_vld), 0);
    chk(int'(lost_cnt) == 57, "R5 refire lost", int'(lost_cnt), 57);
    repeat (C + 1) cyc('0);

    // R8: continuous pixel 9 -> regrant at edge C+2 after first grant
    cyc(32'h1 << 9);
    chk(gnt_vld[0] == 1'b1, "R8 first grant", int'(gnt_vld[0]), 1);
    for (int i = 2; i <= C + 1; i++) cyc(32'h1 << 9);
    chk(evt_vld[0] == 1'b1 && ch_busy[0] == 1'b0, "R8 channel freed", int'(evt_vld[0]), 1);
    cyc(32'h1 << 9);
    chk(gnt_vld[0] == 1'b1 && int'(gnt_pix[4:0]) == 9, "R8 regrant next edge",
        int'(gnt_vld[0]), 1);
    repeat (C + 1) cyc('0);

    // wrap corner: pixels 31 and 0
    cyc(32'h8000_0001);
    repeat (C + 1) cyc('0);

    // random traffic at several densities
    for (int i = 0; i < 3000; i++) begin
      int dens;
      dens = (i < 1000) ? 24 : (i < 2000) ? 8 : 3;
      for (int b = 0; b < NPIX; b++) r[b] = (($urandom % dens) == 0);
      cyc(r);
    end

    // R6 saturation
    for (int i = 0; i < 2200; i++) cyc('1);
    chk(lost_cnt == 16'hFFFF, "R6 saturated", int'(lost_cnt), 65535);
    repeat (10) cyc('1);
    chk(lost_cnt == 16'hFFFF, "R6 stays saturated", int'(lost_cnt), 65535);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule